// File: doc/BRIEF.md
# Interrupt Vector Fetch Insertion Unit

This unit sequences the program address of a three-stage fetch/decode/execute pipeline and splices interrupt handling into it. A request on `irq_req` is caught in a pending latch. The unit lets one more ordinary fetch go out, which is the decode slot of the instruction that was being fetched when the request arrived. It then moves the program address source from the program counter to the interrupt start address for two consecutive fetches, first the start address and then the start address plus one. The program counter is held over those two fetches. Once they are done, ordinary fetching continues from the held counter value.

It is not a full context switch. The two inserted words are fetched like any other instruction words and run in the normal stream. Every advancing cycle is treated as an instruction boundary. A low `advance` stalls the whole unit without it losing its place.

Top module: `irq_fetch_splice`

## Requirements
- R1: While reset is held and until the first advancing cycle after it, `prog_addr` equals parameter RESET_PC and `pc_hold` is 0. Reset is asserted asynchronously and released through a two-stage synchronizer.
- R2: With no request pending and no insertion running, `prog_addr` rises by one after each cycle with `advance` high. It keeps its value after a cycle with `advance` low.
- R3: A high `irq_req` at a clock edge sets the pending latch. In the cycle after that edge, `prog_addr` still shows the counter (one more ordinary fetch) and `pc_hold` stays 0.
- R4: In the first inserted fetch, `prog_addr` equals the `vec_base` value sampled on the advancing edge that enters that fetch, and `pc_hold` is 1. Later changes of `vec_base` do not affect the pair.
- R5: In the second inserted fetch, `prog_addr` equals that sampled start address plus one, and `pc_hold` is 1.
- R6: After the second inserted fetch, `pc_hold` returns to 0 and `prog_addr` resumes at the counter value held since the ordinary fetch of R3, plus one.
- R7: Each accepted request gives exactly two advancing cycles with `pc_hold` high.
- R8: The pending latch clears when the first inserted word is fetched. A request that arrives during an insertion is held and starts a new insertion after one ordinary fetch. No further insertion follows it.
- R9: With `advance` low during an insertion, `prog_addr` and `pc_hold` hold and the sequence keeps its position.
- R10: With `advance` low while a request is pending but no insertion has started yet, the unit stays in that state until the next advancing cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | Interrupt request, sampled at each edge |
| vec_base | input | AW | Interrupt start address |
| advance | input | 1 | Pipeline advance; low stalls the unit |
| prog_addr | output | AW | Program address bus |
| pc_hold | output | 1 | High while the program counter is frozen |

## Verification
Two events can land in the same cycle: a new request and the clearing of the pending latch as the first inserted word is fetched. The bench raises `irq_req` in exactly that cycle. It then expects one ordinary fetch at the resumed counter, one more full two-word insertion, and plain counting after that. Stalls are also placed in every phase of the sequence (armed, first word, second word), and each stalled cycle is checked to show an unchanged address and hold flag.

// File: rtl/irq_fetch_splice_pkg.sv
package irq_fetch_splice_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_WORD0 = 2'd1,
    ST_WORD1 = 2'd2
  } splice_state_e;
endpackage

// File: rtl/ifs_rst_sync.sv
module ifs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/ifs_pend_latch.sv
module ifs_pend_latch (
  input  logic clk,
  input  logic srst_n,
  input  logic irq_req,
  input  logic clr,
  output logic pend
);
  logic pend_q, pend_d;

  // a fresh request wins over the clear of the same cycle
  always_comb begin
    pend_d = pend_q;
    if (clr)     pend_d = 1'b0;
    if (irq_req) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end

  assign pend = pend_q;
endmodule

// File: rtl/ifs_seq.sv
module ifs_seq
  import irq_fetch_splice_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic          advance,
  input  logic          pend,
  input  logic [AW-1:0] vec_base,
  output splice_state_e state,
  output logic [AW-1:0] vec_q,
  output logic          clr_pend
);
  splice_state_e st_q, st_d;
  logic [AW-1:0] vec_d;
  logic          vec_en;

  always_comb begin
    st_d   = st_q;
    vec_en = 1'b0;
    unique case (st_q)
      ST_RUN: begin
        if (advance && pend) begin
          st_d   = ST_WORD0;
          vec_en = 1'b1;
        end
      end
      ST_WORD0: if (advance) st_d = ST_WORD1;
      ST_WORD1: if (advance) st_d = ST_RUN;
      default:  st_d = ST_RUN;
    endcase
  end

  assign vec_d    = vec_en ? vec_base : vec_q;
  assign clr_pend = (st_q == ST_WORD0) && advance;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q  <= ST_RUN;
      vec_q <= '0;
    end else begin
      st_q  <= st_d;
      vec_q <= vec_d;
    end
  end

  assign state = st_q;
endmodule

// File: rtl/ifs_addr_path.sv
module ifs_addr_path
  import irq_fetch_splice_pkg::*;
#(
  parameter int unsigned AW       = 16,
  parameter int unsigned RESET_PC = 256
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic          advance,
  input  splice_state_e state,
  input  logic [AW-1:0] vec_q,
  output logic [AW-1:0] prog_addr,
  output logic          pc_hold
);
  localparam logic [AW-1:0] PC_INIT = AW'(RESET_PC);
  localparam logic [AW-1:0] ONE     = AW'(1);

  logic [AW-1:0] pc_q, pc_d;
  logic          pc_en;

  assign pc_en = advance && (state == ST_RUN);
  assign pc_d  = pc_en ? (pc_q + ONE) : pc_q;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) pc_q <= PC_INIT;
    else         pc_q <= pc_d;
  end

  always_comb begin
    unique case (state)
      ST_WORD0: prog_addr = vec_q;
      ST_WORD1: prog_addr = vec_q + ONE;
      default:  prog_addr = pc_q;
    endcase
  end

  assign pc_hold = (state != ST_RUN);
endmodule

// File: rtl/irq_fetch_splice.sv
module irq_fetch_splice
  import irq_fetch_splice_pkg::*;
#(
  parameter int unsigned AW       = 16,
  parameter int unsigned RESET_PC = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq_req,
  input  logic [AW-1:0] vec_base,
  input  logic          advance,
  output logic [AW-1:0] prog_addr,
  output logic          pc_hold
);
  logic          srst_n;
  logic          pend;
  logic          clr_pend;
  splice_state_e state;
  logic [AW-1:0] vec_q;

  ifs_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  ifs_pend_latch u_pend (
    .clk     (clk),
    .srst_n  (srst_n),
    .irq_req (irq_req),
    .clr     (clr_pend),
    .pend    (pend)
  );

  ifs_seq #(.AW(AW)) u_seq (
    .clk      (clk),
    .srst_n   (srst_n),
    .advance  (advance),
    .pend     (pend),
    .vec_base (vec_base),
    .state    (state),
    .vec_q    (vec_q),
    .clr_pend (clr_pend)
  );

  ifs_addr_path #(.AW(AW), .RESET_PC(RESET_PC)) u_addr (
    .clk       (clk),
    .srst_n    (srst_n),
    .advance   (advance),
    .state     (state),
    .vec_q     (vec_q),
    .prog_addr (prog_addr),
    .pc_hold   (pc_hold)
  );
endmodule

// File: rtl/irq_fetch_splice_chk.sv
module irq_fetch_splice_chk
  import irq_fetch_splice_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input logic          clk,
  input logic          srst_n,
  input logic          advance,
  input logic          pend,
  input splice_state_e state,
  input logic [AW-1:0] prog_addr,
  input logic          pc_hold
);
  logic [1:0] hold_cnt;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)                hold_cnt <= 2'd0;
    else if (!pc_hold)          hold_cnt <= 2'd0;
    else if (advance && hold_cnt != 2'd3) hold_cnt <= hold_cnt + 2'd1;
  end

  AST_RUN_STEP: assert property (@(posedge clk) disable iff (!srst_n)
    advance && !pc_hold |=> pc_hold || (prog_addr == $past(prog_addr) + AW'(1))); // R2

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!srst_n)
    !advance |=> $stable(prog_addr) && $stable(pc_hold)); // R9

  AST_PEND_ENTERS: assert property (@(posedge clk) disable iff (!srst_n)
    pend && advance && !pc_hold |=> pc_hold); // R4

  AST_SECOND_WORD: assert property (@(posedge clk) disable iff (!srst_n)
    (state == ST_WORD0) && advance |=> pc_hold && (prog_addr == $past(prog_addr) + AW'(1))); // R5

  AST_RESUME: assert property (@(posedge clk) disable iff (!srst_n)
    (state == ST_WORD1) && advance |=> !pc_hold); // R6

  AST_TWO_WORDS: assert property (@(posedge clk) disable iff (!srst_n)
    hold_cnt <= 2'd2); // R7
endmodule

bind irq_fetch_splice irq_fetch_splice_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .srst_n    (srst_n),
  .advance   (advance),
  .pend      (pend),
  .state     (state),
  .prog_addr (prog_addr),
  .pc_hold   (pc_hold)
);

// File: tb/tb_irq_fetch_splice.sv
`timescale 1ns/1ps
module tb_irq_fetch_splice;
  localparam int unsigned AW       = 16;
  localparam int unsigned RESET_PC = 256;

  logic          clk;
  logic          rst_n;
  logic          irq_req;
  logic [AW-1:0] vec_base;
  logic          advance;
  logic [AW-1:0] prog_addr;
  logic          pc_hold;

  int checks;
  int fails;
  bit done;
  logic [AW-1:0] p;

  irq_fetch_splice #(.AW(AW), .RESET_PC(RESET_PC)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req   (irq_req),
    .vec_base  (vec_base),
    .advance   (advance),
    .prog_addr (prog_addr),
    .pc_hold   (pc_hold)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic tick(input logic irq, input logic adv);
    irq_req = irq;
    advance = adv;
    @(posedge clk);
    #1;
    irq_req = 1'b0;
  endtask

  task automatic expect_out(input string req, input logic [AW-1:0] ea, input logic eh);
    checks++;
    if (prog_addr !== ea) begin
      fails++;
      $display("FAIL %s prog_addr actual %h expected %h", req, prog_addr, ea);
    end
    checks++;
    if (pc_hold !== eh) begin
      fails++;
      $display("FAIL %s pc_hold actual %b expected %b", req, pc_hold, eh);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; irq_req = 1'b0; advance = 1'b0; vec_base = '0;
    repeat (3) @(posedge clk);
    #1;
    expect_out("R1", AW'(RESET_PC), 1'b0);
    rst_n = 1'b1;
    repeat (3) tick(1'b0, 1'b0);
    expect_out("R1", AW'(RESET_PC), 1'b0);
    p = AW'(RESET_PC);
  endtask

  task automatic t_run();
    tick(0, 1); p = p + 1; expect_out("R2", p, 0);
    tick(0, 1); p = p + 1; expect_out("R2", p, 0);
    tick(0, 0);            expect_out("R2", p, 0);
    tick(0, 1); p = p + 1; expect_out("R2", p, 0);
  endtask

  task automatic t_basic();
    vec_base = 16'h2000;
    tick(1, 1); p = p + 1; expect_out("R3", p, 0);
    tick(0, 1); expect_out("R4", 16'h2000, 1);
    tick(0, 1); expect_out("R5", 16'h2001, 1);
    tick(0, 1); p = p + 1; expect_out("R6", p, 0);
    tick(0, 1); p = p + 1; expect_out("R7", p, 0);
  endtask

  task automatic t_stalls();
    vec_base = 16'h3000;
    tick(1, 0); expect_out("R10", p, 0);
    tick(0, 0); expect_out("R10", p, 0);
    tick(0, 1); expect_out("R4", 16'h3000, 1);
    tick(0, 0); expect_out("R9", 16'h3000, 1);
    tick(0, 1); expect_out("R5", 16'h3001, 1);
    tick(0, 0); expect_out("R9", 16'h3001, 1);
    tick(0, 1); p = p + 1; expect_out("R6", p, 0);
  endtask

  task automatic t_vec_change();
    vec_base = 16'h4400;
    tick(1, 1); p = p + 1; expect_out("R3", p, 0);
    tick(0, 1); expect_out("R4", 16'h4400, 1);
    vec_base = 16'h5500;
    tick(0, 1); expect_out("R4", 16'h4401, 1);
    tick(0, 1); p = p + 1; expect_out("R6", p, 0);
  endtask

  task automatic t_back_to_back();
    vec_base = 16'h6000;
    tick(1, 1); p = p + 1; expect_out("R8", p, 0);
    tick(0, 1); expect_out("R8", 16'h6000, 1);
    tick(1, 1); expect_out("R8", 16'h6001, 1);
    tick(0, 1); p = p + 1; expect_out("R8", p, 0);
    tick(0, 1); expect_out("R8", 16'h6000, 1);
    tick(0, 1); expect_out("R8", 16'h6001, 1);
    tick(0, 1); p = p + 1; expect_out("R8", p, 0);
    tick(0, 1); p = p + 1; expect_out("R8", p, 0);
  endtask

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    t_reset();
    t_run();
    t_basic();
    t_stalls();
    t_vec_change();
    t_back_to_back();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule